// File: doc/BRIEF.md
# Event Counter Snapshot Bank

This block holds a bank of event counters. On an update request it copies the counters into holding registers and clears the counters on the same clock edge. Software then reads a stable, coherent set of counts from the holding registers while counting goes on. Each channel counts one-cycle increment strobes. A channel saturates at its all-ones value rather than wrapping.

The update request has two possible sources, and a mode bit picks one. The first is a local request bit in a two-bit control word. The second is a global update pulse shared by many such banks. Only the rising edge of the selected source starts an update, and only channels whose participation enable is high take part.

A completion flag rises when the update happens. In local mode the flag stays high until the request bit is written back to zero, which gives a request/acknowledge handshake. Each channel also keeps a sticky "count became non-zero" flag, which software clears by writing a one to it.

Top module: `pmsnap_top`

## Requirements
- R1: After reset, both control bits (bit 0 = local request, bit 1 = source mode) read 0, the completion flag is 0, all non-zero flags are 0, and every holding register reads 0.
- R2: Each cycle with a channel's increment input high adds one to that channel's counter. The counter stops at 2^CNT_W-1 and does not wrap.
- R3: With mode 0, a rising edge of the request bit triggers an update. Every enabled channel's count moves into its holding register and the counter clears. Holding the request bit high does not trigger further updates.
- R4: With mode 1, a rising edge of the global update input triggers the update, and the local request bit has no effect.
- R5: A channel whose enable is 0 during an update keeps its previous holding value, and its counter keeps its count.
- R6: The completion flag goes high on the edge that performs the update. It stays high while the request bit is 1 and drops on the first edge after the request bit reads 0.
- R7: If an increment arrives in the same cycle as a channel's update clear, that counter restarts at 1 and the channel's non-zero flag is set.
- R8: A channel's non-zero flag is set when its counter leaves 0. Writing 1 to its clear bit resets the flag, but a set in the same cycle takes priority over the clear. The flag never drops without a clear.
- R9: The read data shows the holding register selected by the read address one clock after that address is presented. Addresses at or above NUM_CH return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 2 | Control word: bit 0 request, bit 1 source mode |
| glob_upd | input | 1 | Global update pulse, synchronous |
| ch_en | input | NUM_CH | Per-channel participation in updates |
| evt_inc | input | NUM_CH | Per-channel increment strobes |
| nz_w1c | input | NUM_CH | Write-one-to-clear strobes for non-zero flags |
| rd_addr | input | $clog2(NUM_CH)+1 | Holding register select |
| ctl_q | output | 2 | Current control word |
| upd_done | output | 1 | Update completion flag |
| nz_lat | output | NUM_CH | Sticky non-zero flags |
| rd_data | output | CNT_W | Selected holding register value |

## Verification
A control write shows on `ctl_q` at the edge that takes it. The edge detector adds one register, so a local request written at edge k is copied into the holding registers and raises `upd_done` at edge k+1. A global pulse present before edge k acts at edge k itself. Increments and non-zero flags change at the edge that samples them, and `rd_data` is due one edge after its address. The bench drives inputs at the falling edge and advances a reference model at each rising edge. It compares all outputs 1 ns after that edge, and directed reads are checked on the step that follows the update.

// File: rtl/pmsnap_pkg.sv
package pmsnap_pkg;

   // Control word layout: bit 0 request, bit 1 source select.
   typedef struct packed {
      logic mode;
      logic req;
   } ctl_t;

   localparam int CTL_W = 2;

   typedef enum logic {
      SRC_LOCAL  = 1'b0,
      SRC_GLOBAL = 1'b1
   } src_sel_e;

endpackage

// File: rtl/pmsnap_ctrl.sv
module pmsnap_ctrl
   import pmsnap_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   input  logic             glob_upd,
   output ctl_t             ctl_r,
   output logic             fire,
   output logic             upd_done
);

   logic src;
   logic src_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_r <= '0;
      end else if (ctl_we) begin
         ctl_r <= ctl_t'(ctl_wdata);
      end
   end

   always_comb begin
      if (src_sel_e'(ctl_r.mode) == SRC_GLOBAL) begin
         src = glob_upd;
      end else begin
         src = ctl_r.req;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_d <= 1'b0;
      end else begin
         src_d <= src;
      end
   end

   assign fire = src & ~src_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         upd_done <= 1'b0;
      end else if (fire) begin
         upd_done <= 1'b1;
      end else if (!ctl_r.req) begin
         upd_done <= 1'b0;
      end
   end

endmodule

// File: rtl/pmsnap_chan.sv
module pmsnap_chan #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt,
   input  logic             snap,
   input  logic             nz_clr,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] hold,
   output logic             nz
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_nxt;
   logic             nz_set;

   always_comb begin
      cnt_nxt = cnt;
      if (snap) begin
         cnt_nxt = evt ? CNT_ONE : '0;
      end else if (evt && (cnt != CNT_MAX)) begin
         cnt_nxt = cnt + CNT_ONE;
      end
   end

   assign nz_set = evt & (snap | (cnt == '0));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         hold <= '0;
         nz   <= 1'b0;
      end else begin
         cnt <= cnt_nxt;
         if (snap) begin
            hold <= cnt;
         end
         nz <= (nz & ~nz_clr) | nz_set;
      end
   end

endmodule

// File: rtl/pmsnap_rdport.sv
module pmsnap_rdport #(
   parameter int NUM_CH   = 4,
   parameter int CNT_W    = 16,
   parameter int RD_AW    = 3,
   parameter bit READ_REG = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_CH*CNT_W-1:0] hold_flat,
   input  logic [RD_AW-1:0]        rd_addr,
   output logic [CNT_W-1:0]        rd_data
);

   logic [CNT_W-1:0] sel;

   always_comb begin
      sel = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (rd_addr == RD_AW'(i)) begin
            sel = hold_flat[i*CNT_W +: CNT_W];
         end
      end
   end

   if (READ_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rd_data <= '0;
         end else begin
            rd_data <= sel;
         end
      end
   end else begin : g_comb
      assign rd_data = sel;
   end

endmodule

// File: rtl/pmsnap_top.sv
module pmsnap_top
   import pmsnap_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int CNT_W    = 16,
   parameter bit READ_REG = 1'b1,
   localparam int RD_AW   = $clog2(NUM_CH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic [1:0]        ctl_wdata,
   input  logic              glob_upd,
   input  logic [NUM_CH-1:0] ch_en,
   input  logic [NUM_CH-1:0] evt_inc,
   input  logic [NUM_CH-1:0] nz_w1c,
   input  logic [RD_AW-1:0]  rd_addr,
   output logic [1:0]        ctl_q,
   output logic              upd_done,
   output logic [NUM_CH-1:0] nz_lat,
   output logic [CNT_W-1:0]  rd_data
);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("pmsnap_top: NUM_CH must be at least 1");
   end
   if (CNT_W < 2) begin : g_bad_w
      $error("pmsnap_top: CNT_W must be at least 2");
   end

   ctl_t                    ctl_r;
   logic                    fire;
   logic [NUM_CH*CNT_W-1:0] cnt_flat;
   logic [NUM_CH*CNT_W-1:0] hold_flat;

   pmsnap_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_we   (ctl_we),
      .ctl_wdata(ctl_wdata),
      .glob_upd (glob_upd),
      .ctl_r    (ctl_r),
      .fire     (fire),
      .upd_done (upd_done)
   );

   assign ctl_q = ctl_r;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      pmsnap_chan #(
         .CNT_W(CNT_W)
      ) u_chan (
         .clk   (clk),
         .rst_n (rst_n),
         .evt   (evt_inc[i]),
         .snap  (fire & ch_en[i]),
         .nz_clr(nz_w1c[i]),
         .cnt   (cnt_flat[i*CNT_W +: CNT_W]),
         .hold  (hold_flat[i*CNT_W +: CNT_W]),
         .nz    (nz_lat[i])
      );
   end

   pmsnap_rdport #(
      .NUM_CH  (NUM_CH),
      .CNT_W   (CNT_W),
      .RD_AW   (RD_AW),
      .READ_REG(READ_REG)
   ) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_flat(hold_flat),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data)
   );

endmodule

// File: rtl/pmsnap_chk.sv
module pmsnap_chk #(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    fire,
   input logic                    ctl_req,
   input logic                    upd_done,
   input logic [NUM_CH-1:0]       nz_lat,
   input logic [NUM_CH-1:0]       nz_w1c,
   input logic [NUM_CH-1:0]       ch_en,
   input logic [NUM_CH-1:0]       evt_inc,
   input logic [NUM_CH*CNT_W-1:0] cnt_flat,
   input logic [NUM_CH*CNT_W-1:0] hold_flat
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   // R6
   done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> upd_done);

   // R6
   done_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_done && ctl_req) |=> upd_done);

   // R6
   done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_done && !ctl_req && !fire) |=> !upd_done);

   // R8
   nz_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nz_w1c == '0) |=> ((nz_lat & $past(nz_lat)) == $past(nz_lat)));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic [CNT_W-1:0] c;
      assign c = cnt_flat[i*CNT_W +: CNT_W];

      // R2
      sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (c == CNT_MAX && !(fire && ch_en[i])) |=> (c == CNT_MAX));

      // R7
      restart_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (fire && ch_en[i] && evt_inc[i]) |=> (c == CNT_W'(1) && nz_lat[i]));

      // R5
      hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(fire && ch_en[i]) |=> $stable(hold_flat[i*CNT_W +: CNT_W]));
   end

endmodule

bind pmsnap_top pmsnap_chk #(
   .NUM_CH(NUM_CH),
   .CNT_W (CNT_W)
) u_pmsnap_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .fire     (fire),
   .ctl_req  (ctl_r.req),
   .upd_done (upd_done),
   .nz_lat   (nz_lat),
   .nz_w1c   (nz_w1c),
   .ch_en    (ch_en),
   .evt_inc  (evt_inc),
   .cnt_flat (cnt_flat),
   .hold_flat(hold_flat)
);

// File: tb/tb_pmsnap_top.sv
`timescale 1ns/1ps
module tb_pmsnap_top;

   localparam int N    = 4;
   localparam int W    = 8;
   localparam int AW   = $clog2(N) + 1;
   localparam int MAXV = (1 << W) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctl_we = 1'b0;
   logic [1:0]    ctl_wdata = '0;
   logic          glob_upd = 1'b0;
   logic [N-1:0]  ch_en = '0;
   logic [N-1:0]  evt_inc = '0;
   logic [N-1:0]  nz_w1c = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [1:0]    ctl_q;
   logic          upd_done;
   logic [N-1:0]  nz_lat;
   logic [W-1:0]  rd_data;

   always #2 clk = ~clk;

   pmsnap_top #(.NUM_CH(N), .CNT_W(W), .READ_REG(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .glob_upd(glob_upd), .ch_en(ch_en), .evt_inc(evt_inc), .nz_w1c(nz_w1c),
      .rd_addr(rd_addr), .ctl_q(ctl_q), .upd_done(upd_done), .nz_lat(nz_lat),
      .rd_data(rd_data)
   );

   int checks = 0;
   int errors = 0;

   // reference model
   int           m_cnt [N];
   int           m_hold[N];
   logic [N-1:0] m_nz = '0;
   logic         m_req = 1'b0, m_mode = 1'b0, m_srcd = 1'b0, m_done = 1'b0;
   int           m_rd = 0;
   logic [N-1:0] en_r = '1;
   int           addr_r = 0;

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
      end
   endtask

   function automatic int rd_model(input int a);
      return (a < N) ? m_hold[a] : 0;
   endfunction

   task automatic step(input logic we, input logic [1:0] wd, input logic g,
                       input logic [N-1:0] ev, input logic [N-1:0] clr);
      logic src, fire, sn;
      @(negedge clk);
      ctl_we = we; ctl_wdata = wd; glob_upd = g; evt_inc = ev; nz_w1c = clr;
      ch_en = en_r; rd_addr = AW'(addr_r);
      @(posedge clk);
      src  = m_mode ? g : m_req;
      fire = src & ~m_srcd;
      m_rd = rd_model(addr_r);
      for (int i = 0; i < N; i++) begin
         sn = ev[i] & ((fire & en_r[i]) | (m_cnt[i] == 0));
         if (fire && en_r[i]) begin
            m_hold[i] = m_cnt[i];
            m_cnt[i]  = ev[i] ? 1 : 0;
         end else if (ev[i] && m_cnt[i] != MAXV) begin
            m_cnt[i]++;
         end
         m_nz[i] = (m_nz[i] & ~clr[i]) | sn;
      end
      if (fire) m_done = 1'b1;
      else if (!m_req) m_done = 1'b0;
      m_srcd = src;
      if (we) {m_mode, m_req} = wd;
      #1;
      chk("R1 control word", int'(ctl_q), int'({m_mode, m_req}));
      chk("R6 completion flag", int'(upd_done), int'(m_done));
      chk("R8 non-zero flags", int'(nz_lat), int'(m_nz));
      chk("R9 read data", int'(rd_data), m_rd);
   endtask

   task automatic idle();
      step(1'b0, 2'b00, 1'b0, '0, '0);
   endtask

   task automatic rd(input int a, input int exp, input string tag);
      addr_r = a;
      idle();
      chk(tag, int'(rd_data), exp);
   endtask

   task automatic local_update();
      step(1'b1, 2'b01, 1'b0, '0, '0);
      idle();
      step(1'b1, 2'b00, 1'b0, '0, '0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_hold[i] = 0; end
      void'($urandom(32'd24680));
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #0.5;
      // R1 reset state
      chk("R1 ctl after reset", int'(ctl_q), 0);
      chk("R1 done after reset", int'(upd_done), 0);
      chk("R1 nz after reset", int'(nz_lat), 0);
      for (int a = 0; a < N; a++) rd(a, 0, "R1 hold after reset");

      // R2 R3 counting and local snapshot
      repeat (5) step(1'b0, 2'b00, 1'b0, 4'b0001, '0);
      repeat (3) step(1'b0, 2'b00, 1'b0, 4'b0011, '0);
      step(1'b1, 2'b01, 1'b0, '0, '0);
      idle();
      chk("R6 done after update", int'(upd_done), 1);
      repeat (4) step(1'b0, 2'b00, 1'b0, 4'b0001, '0);
      chk("R6 done held with request", int'(upd_done), 1);
      rd(0, 8, "R3 ch0 snapshot");
      rd(1, 3, "R2 ch1 snapshot");
      rd(2, 0, "R2 ch2 snapshot");
      step(1'b1, 2'b00, 1'b0, '0, '0);
      idle();
      chk("R6 done cleared", int'(upd_done), 0);
      rd(0, 8, "R3 no repeat while held");
      local_update();
      rd(0, 4, "R3 second snapshot");

      // R7 same-cycle event and clear
      step(1'b0, 2'b00, 1'b0, '0, '1);
      step(1'b1, 2'b01, 1'b0, '0, '0);
      step(1'b0, 2'b00, 1'b0, 4'b0001, '0);
      chk("R7 nz on restart", int'(nz_lat[0]), 1);
      step(1'b1, 2'b00, 1'b0, '0, '0);
      local_update();
      rd(0, 1, "R7 restart at one");

      // R5 disabled channel
      en_r = 4'b1101;
      repeat (2) step(1'b0, 2'b00, 1'b0, 4'b0010, '0);
      local_update();
      rd(1, 0, "R5 disabled hold kept");
      en_r = 4'b1111;
      local_update();
      rd(1, 2, "R5 disabled counter kept");

      // R4 global source
      step(1'b1, 2'b10, 1'b0, '0, '0);
      repeat (6) step(1'b0, 2'b10, 1'b0, 4'b0100, '0);
      step(1'b1, 2'b11, 1'b0, '0, '0);
      idle();
      rd(2, 0, "R4 local bit ignored");
      step(1'b0, 2'b00, 1'b1, '0, '0);
      chk("R4 done after global", int'(upd_done), 1);
      rd(2, 6, "R4 global snapshot");
      step(1'b1, 2'b10, 1'b0, '0, '0);
      step(1'b1, 2'b00, 1'b0, '0, '0);

      // R2 saturation
      repeat (300) step(1'b0, 2'b00, 1'b0, 4'b1000, '0);
      local_update();
      rd(3, MAXV, "R2 saturation");

      // R8 write-one-to-clear
      step(1'b0, 2'b00, 1'b0, '0, '1);
      chk("R8 cleared", int'(nz_lat), 0);
      step(1'b0, 2'b00, 1'b0, 4'b0001, 4'b0001);
      chk("R8 set wins over clear", int'(nz_lat), 1);
      step(1'b0, 2'b00, 1'b0, 4'b0001, 4'b0001);
      chk("R8 clear when no set", int'(nz_lat), 0);

      // R9 read port
      rd(5, 0, "R9 out of range");
      rd(3, MAXV, "R9 in range");

      // random phase against the model
      for (int k = 0; k < 3000; k++) begin
         logic          we, g;
         logic [1:0]    wd;
         logic [N-1:0]  ev, clr;
         we  = ($urandom % 8) == 0;
         wd  = 2'($urandom);
         g   = ($urandom % 12) == 0;
         ev  = N'($urandom);
         clr = (($urandom % 8) == 0) ? N'($urandom) : '0;
         if (($urandom % 50) == 0) en_r = N'($urandom);
         addr_r = int'($urandom % (1 << AW));
         step(we, wd, g, ev, clr);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule